// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block takes over an 8-bit CPU between two instructions when an exception or interrupt is pending. It picks one winner from four sources (a reset request, a non-maskable request, a fast maskable request and a normal maskable request). It then runs that source's entry sequence. The sequence can write the machine state onto the system stack through a byte-wide write port. It then reads a two-byte vector through the same port and reports the new program counter, the updated condition-code byte, the final stack pointer and the cycle cost of the entry.

The CPU pulses `boundary` at the end of each instruction and keeps the register inputs steady while `busy` is high. When `done` pulses, the CPU copies `pc_out`, `cc_out` and `sp_out` into its register file and clears its direct-page register if `dp_clear` is set. It then adds `cost` to its cycle counter. The state machine has six states: IDLE, PUSH, VEC_HI, VEC_LO, VEC_TAIL and DONE. It moves through them as follows:

- From IDLE, an accepted boundary goes to PUSH, or straight to VEC_HI for a reset entry.
- PUSH repeats until the last byte, which is the condition-code byte, has been written, then goes to VEC_HI.
- VEC_HI goes to VEC_LO, then VEC_TAIL, then DONE, and DONE returns to IDLE.

Top module: `irq_entry_seq`

## Requirements
- R1: At a `boundary` strobe in IDLE, the winner is chosen in this order: a pending reset, then a pending non-maskable request, then `req_firq`, then `req_irq`. An asserted `req_firq` that is masked blocks `req_irq` at that boundary. At most one entry starts per boundary.
- R2: A reset entry writes nothing to memory. It sets `dp_clear` and loads the PC from the vector at 0xFFFE. A one-cycle `req_reset` pulse produces exactly one entry.
- R3: The non-maskable request is edge-triggered. A rising edge of `req_nmi` stays pending until it is serviced. Holding `req_nmi` high causes no second entry.
- R4: A full frame (non-maskable and normal requests) writes 12 bytes at addresses S-1, S-2 and so on downward. The byte order is: PC low, PC high, U low, U high, Y low, Y high, X low, X high, DP, B, A, CC. `sp_out` ends at S-12.
- R5: A fast frame (`req_firq`) writes only PC low, PC high and CC, at S-1 down to S-3. The stacked CC has bit 7 (E) cleared, and `sp_out` ends at S-3.
- R6: CC bit 7 is E, bit 6 is F and bit 4 is I; the other bits pass through. The stacked CC carries the new E value, with F and I still as they were on entry. The entries update `cc_out` as follows:
  - non-maskable: sets E, F and I.
  - normal: sets E and I and leaves F unchanged.
  - fast: clears E and sets F and I.
  - reset: sets F and I and leaves E unchanged.
- R7: The vector is read high byte first, from the vector address and then from the next address. Read data arrives on `mem_rdata` one cycle after `mem_re`. The vector addresses are 0xFFFC (non-maskable), 0xFFF6 (fast) and 0xFFF8 (normal).
- R8: `kind_out` encodes the serviced source as 0 reset, 1 non-maskable, 2 fast, 3 normal. `cost` reports 19 for non-maskable and normal entries, 10 for fast entries and 0 for reset.
- R9: `req_firq` is taken only when F is 0 and `req_irq` only when I is 0. Both are level inputs that the block never clears, so a request still asserted at a later boundary is taken again.
- R10: `busy` rises in the cycle after the accepted boundary and stays high for (bytes written + 4) cycles. `done` pulses in the last of those cycles. A `boundary` strobe while busy is ignored, and `mem_we` and `mem_re` are never high together.
- R11: After reset, `busy`, `done`, `mem_we` and `mem_re` are low.
- R12: A boundary with no request, or with only masked requests, starts no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary | input | 1 | Instruction-boundary strobe |
| req_reset | input | 1 | Reset request pulse |
| req_nmi | input | 1 | Non-maskable request (edge) |
| req_firq | input | 1 | Fast maskable request (level) |
| req_irq | input | 1 | Normal maskable request (level) |
| cc_in | input | 8 | Current condition-code byte |
| reg_a | input | 8 | Accumulator A |
| reg_b | input | 8 | Accumulator B |
| reg_dp | input | 8 | Direct-page register |
| reg_x | input | 16 | Index X |
| reg_y | input | 16 | Index Y |
| reg_u | input | 16 | User stack pointer |
| reg_s | input | 16 | System stack pointer |
| reg_pc | input | 16 | Return PC |
| mem_rdata | input | 8 | Read data, one cycle after mem_re |
| mem_we | output | 1 | Byte write request |
| mem_re | output | 1 | Byte read request |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | New PC from the vector |
| sp_out | output | 16 | Final system stack pointer |
| cc_out | output | 8 | Updated condition-code byte |
| dp_clear | output | 1 | Clear DP (reset entry) |
| cost | output | 8 | Cycle cost of the entry |
| kind_out | output | 2 | Serviced source |

## Verification
The assertions check the following on every cycle:
- the write and read strobes are never high together;
- each stack write lands one address below the previous one;
- the second vector read follows the first at the next address;
- `done` releases `busy` on the next cycle;
- every completed entry leaves I set, a full frame leaves the stack pointer twelve below its start, and a fast entry leaves E clear and F set.

Only the bench scenarios can show the rest:
- the arbitration order, including a masked fast request blocking the normal one;
- one service per non-maskable edge, and re-entry on a still-asserted level request;
- the exact byte sequence of each frame and the big-endian vector assembly.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [1:0] {
        K_RESET = 2'd0,
        K_NMI   = 2'd1,
        K_FIRQ  = 2'd2,
        K_IRQ   = 2'd3
    } kind_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH,
        S_VEC_HI,
        S_VEC_LO,
        S_VEC_TAIL,
        S_DONE
    } state_t;

    localparam int CC_E = 7;
    localparam int CC_F = 6;
    localparam int CC_I = 4;

    localparam logic [7:0] M_E = 8'h80;
    localparam logic [7:0] M_F = 8'h40;
    localparam logic [7:0] M_I = 8'h10;

    localparam int FRAME_FULL = 12;
    localparam int FRAME_FAST = 3;

endpackage

// File: rtl/irq_seq_arb.sv
module irq_seq_arb
    import irq_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  req_reset,
    input  logic  req_nmi,
    input  logic  req_firq,
    input  logic  req_irq,
    input  logic  mask_f,
    input  logic  mask_i,
    input  logic  take,
    output logic  win_valid,
    output kind_t win_kind
);

    logic rst_pend;
    logic nmi_pend;
    logic nmi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_pend <= 1'b0;
            nmi_pend <= 1'b0;
            nmi_q    <= 1'b0;
        end else begin
            nmi_q <= req_nmi;
            if (take && win_kind == K_RESET) rst_pend <= 1'b0;
            if (req_reset)                   rst_pend <= 1'b1;
            if (take && win_kind == K_NMI)   nmi_pend <= 1'b0;
            if (req_nmi && !nmi_q)           nmi_pend <= 1'b1;
        end
    end

    // Fixed priority; a masked fast request still shadows the normal one.
    always_comb begin
        win_valid = 1'b0;
        win_kind  = K_IRQ;
        if (rst_pend) begin
            win_valid = 1'b1;
            win_kind  = K_RESET;
        end else if (nmi_pend) begin
            win_valid = 1'b1;
            win_kind  = K_NMI;
        end else if (req_firq) begin
            win_valid = !mask_f;
            win_kind  = K_FIRQ;
        end else if (req_irq) begin
            win_valid = !mask_i;
            win_kind  = K_IRQ;
        end
    end

endmodule

// File: rtl/irq_seq_frame.sv
module irq_seq_frame (
    input  logic [3:0]  idx,
    input  logic [15:0] pc,
    input  logic [15:0] u,
    input  logic [15:0] y,
    input  logic [15:0] x,
    input  logic [7:0]  dp,
    input  logic [7:0]  b,
    input  logic [7:0]  a,
    input  logic [7:0]  cc,
    output logic [7:0]  byte_out
);

    always_comb begin
        unique case (idx)
            4'd0:    byte_out = pc[7:0];
            4'd1:    byte_out = pc[15:8];
            4'd2:    byte_out = u[7:0];
            4'd3:    byte_out = u[15:8];
            4'd4:    byte_out = y[7:0];
            4'd5:    byte_out = y[15:8];
            4'd6:    byte_out = x[7:0];
            4'd7:    byte_out = x[15:8];
            4'd8:    byte_out = dp;
            4'd9:    byte_out = b;
            4'd10:   byte_out = a;
            default: byte_out = cc;
        endcase
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter logic [15:0] VEC_RESET  = 16'hFFFE,
    parameter logic [15:0] VEC_NMI    = 16'hFFFC,
    parameter logic [15:0] VEC_FIRQ   = 16'hFFF6,
    parameter logic [15:0] VEC_IRQ    = 16'hFFF8,
    parameter int          COST_W     = 8,
    parameter int          COST_FULL  = 19,
    parameter int          COST_FAST  = 10,
    parameter int          COST_RESET = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary,
    input  logic              req_reset,
    input  logic              req_nmi,
    input  logic              req_firq,
    input  logic              req_irq,
    input  logic [7:0]        cc_in,
    input  logic [7:0]        reg_a,
    input  logic [7:0]        reg_b,
    input  logic [7:0]        reg_dp,
    input  logic [15:0]       reg_x,
    input  logic [15:0]       reg_y,
    input  logic [15:0]       reg_u,
    input  logic [15:0]       reg_s,
    input  logic [15:0]       reg_pc,
    input  logic [7:0]        mem_rdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [15:0]       mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              busy,
    output logic              done,
    output logic [15:0]       pc_out,
    output logic [15:0]       sp_out,
    output logic [7:0]        cc_out,
    output logic              dp_clear,
    output logic [COST_W-1:0] cost,
    output logic [1:0]        kind_out
);

    localparam logic [3:0] LAST_IDX = 4'(FRAME_FULL - 1);
    localparam logic [3:0] FAST_HOP = 4'(FRAME_FAST - 2);

    state_t            state, nxt;
    kind_t             win_kind, kind_r;
    logic              win_valid, take;
    logic [3:0]        pidx;
    logic [15:0]       sp_r, vaddr, pc_r, vec_sel;
    logic [7:0]        cc_stk, cc_r, cc_new, frame_byte;
    logic [COST_W-1:0] cost_r, cost_sel;
    logic              dp_clr_r;

    assign take = (state == S_IDLE) && boundary && win_valid;

    irq_seq_arb u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_reset(req_reset),
        .req_nmi  (req_nmi),
        .req_firq (req_firq),
        .req_irq  (req_irq),
        .mask_f   (cc_in[CC_F]),
        .mask_i   (cc_in[CC_I]),
        .take     (take),
        .win_valid(win_valid),
        .win_kind (win_kind)
    );

    irq_seq_frame u_frame (
        .idx     (pidx),
        .pc      (reg_pc),
        .u       (reg_u),
        .y       (reg_y),
        .x       (reg_x),
        .dp      (reg_dp),
        .b       (reg_b),
        .a       (reg_a),
        .cc      (cc_stk),
        .byte_out(frame_byte)
    );

    // Per-source entry attributes
    always_comb begin
        unique case (win_kind)
            K_RESET: begin
                cc_new = cc_in | M_F | M_I;
                vec_sel = VEC_RESET;
                cost_sel = COST_W'(COST_RESET);
            end
            K_NMI: begin
                cc_new = cc_in | M_E | M_F | M_I;
                vec_sel = VEC_NMI;
                cost_sel = COST_W'(COST_FULL);
            end
            K_FIRQ: begin
                cc_new = (cc_in & ~M_E) | M_F | M_I;
                vec_sel = VEC_FIRQ;
                cost_sel = COST_W'(COST_FAST);
            end
            default: begin
                cc_new = cc_in | M_E | M_I;
                vec_sel = VEC_IRQ;
                cost_sel = COST_W'(COST_FULL);
            end
        endcase
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:     if (take) nxt = (win_kind == K_RESET) ? S_VEC_HI : S_PUSH;
            S_PUSH:     if (pidx == LAST_IDX) nxt = S_VEC_HI;
            S_VEC_HI:   nxt = S_VEC_LO;
            S_VEC_LO:   nxt = S_VEC_TAIL;
            S_VEC_TAIL: nxt = S_DONE;
            S_DONE:     nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_r   <= K_RESET;
            pidx     <= 4'd0;
            sp_r     <= 16'd0;
            vaddr    <= 16'd0;
            pc_r     <= 16'd0;
            cc_stk   <= 8'd0;
            cc_r     <= 8'd0;
            cost_r   <= '0;
            dp_clr_r <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (take) begin
                    kind_r   <= win_kind;
                    pidx     <= 4'd0;
                    sp_r     <= reg_s;
                    vaddr    <= vec_sel;
                    cc_stk   <= (win_kind == K_FIRQ) ? (cc_in & ~M_E) : (cc_in | M_E);
                    cc_r     <= cc_new;
                    cost_r   <= cost_sel;
                    dp_clr_r <= (win_kind == K_RESET);
                end
                S_PUSH: begin
                    sp_r <= sp_r - 16'd1;
                    pidx <= (kind_r == K_FIRQ && pidx == FAST_HOP) ? LAST_IDX : pidx + 4'd1;
                end
                S_VEC_LO:   pc_r[15:8] <= mem_rdata;
                S_VEC_TAIL: pc_r[7:0]  <= mem_rdata;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_we    = (state == S_PUSH);
        mem_re    = (state == S_VEC_HI) || (state == S_VEC_LO);
        mem_wdata = mem_we ? frame_byte : 8'd0;
        unique case (state)
            S_PUSH:   mem_addr = sp_r - 16'd1;
            S_VEC_HI: mem_addr = vaddr;
            S_VEC_LO: mem_addr = vaddr + 16'd1;
            default:  mem_addr = 16'd0;
        endcase
        busy = (state != S_IDLE);
        done = (state == S_DONE);
    end

    assign pc_out   = pc_r;
    assign sp_out   = sp_r;
    assign cc_out   = cc_r;
    assign cost     = cost_r;
    assign dp_clear = dp_clr_r;
    assign kind_out = kind_r;

    // R10
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R4
    stack_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (!mem_we || mem_addr == $past(mem_addr) - 16'd1));

    // R7
    vec_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (!mem_re || mem_addr == $past(mem_addr) + 16'd1));

    // R10
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R6
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cc_out[CC_I]);

    // R5
    fast_e_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind_out == 2'd2) |-> (!cc_out[CC_E] && cc_out[CC_F]));

    // R4
    full_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (kind_out == 2'd1 || kind_out == 2'd3)) |-> sp_out == reg_s - 16'd12);

endmodule

// File: tb/irq_entry_seq_tb.sv
`timescale 1ns/1ps
module irq_entry_seq_tb;

    typedef struct packed {
        logic [3:0]  req;   // {reset, nmi, firq, irq}
        logic [7:0]  cc;
        logic [2:0]  kind;  // 7 = no entry expected
        logic [7:0]  ccout;
        logic [15:0] pc;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{4'b1000, 8'h00, 3'd0, 8'h50, 16'hDEF0},
        '{4'b0100, 8'h50, 3'd1, 8'hD0, 16'h9ABC},
        '{4'b0010, 8'h8F, 3'd2, 8'h5F, 16'h1234},
        '{4'b0001, 8'h05, 3'd3, 8'h95, 16'h5678},
        '{4'b0001, 8'h10, 3'd7, 8'h00, 16'h0000},
        '{4'b0010, 8'h40, 3'd7, 8'h00, 16'h0000},
        '{4'b0011, 8'h40, 3'd7, 8'h00, 16'h0000},
        '{4'b0011, 8'h00, 3'd2, 8'h50, 16'h1234},
        '{4'b0111, 8'h00, 3'd1, 8'hD0, 16'h9ABC},
        '{4'b0001, 8'h40, 3'd3, 8'hD0, 16'h5678},
        '{4'b1001, 8'h00, 3'd0, 8'h50, 16'hDEF0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic boundary = 0, req_reset = 0, req_nmi = 0, req_firq = 0, req_irq = 0;
    logic [7:0]  cc_in = 8'h00;
    logic [7:0]  reg_a = 8'hBB, reg_b = 8'hAA, reg_dp = 8'h99;
    logic [15:0] reg_x = 16'h7788, reg_y = 16'h5566, reg_u = 16'h3344;
    logic [15:0] reg_s = 16'h8000, reg_pc = 16'h1122;
    logic [7:0]  mem_rdata = 8'h00;
    logic        mem_we, mem_re, busy, done, dp_clear;
    logic [15:0] mem_addr, pc_out, sp_out;
    logic [7:0]  mem_wdata, cc_out, cost;
    logic [1:0]  kind_out;

    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    irq_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n), .boundary(boundary),
        .req_reset(req_reset), .req_nmi(req_nmi), .req_firq(req_firq), .req_irq(req_irq),
        .cc_in(cc_in), .reg_a(reg_a), .reg_b(reg_b), .reg_dp(reg_dp),
        .reg_x(reg_x), .reg_y(reg_y), .reg_u(reg_u), .reg_s(reg_s), .reg_pc(reg_pc),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .busy(busy), .done(done), .pc_out(pc_out),
        .sp_out(sp_out), .cc_out(cc_out), .dp_clear(dp_clear), .cost(cost),
        .kind_out(kind_out)
    );

    function automatic logic [7:0] vec_byte(input logic [15:0] a);
        case (a)
            16'hFFF6: return 8'h12;  16'hFFF7: return 8'h34;
            16'hFFF8: return 8'h56;  16'hFFF9: return 8'h78;
            16'hFFFC: return 8'h9A;  16'hFFFD: return 8'hBC;
            16'hFFFE: return 8'hDE;  16'hFFFF: return 8'hF0;
            default:  return 8'h00;
        endcase
    endfunction

    always @(posedge clk) mem_rdata <= mem_re ? vec_byte(mem_addr) : 8'h00;

    function automatic logic [7:0] exp_byte(input logic [2:0] k, input int i, input logic [7:0] scc);
        logic [7:0] full [12];
        full = '{8'h22, 8'h11, 8'h44, 8'h33, 8'h66, 8'h55, 8'h88, 8'h77,
                 8'h99, 8'hAA, 8'hBB, scc};
        if (k == 3'd2) return (i < 2) ? full[i] : scc;
        return full[i];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic serve(input logic [2:0] ek, input logic [7:0] ccin, input logic [7:0] ecc,
                         input logic [15:0] epc, input bit mid_strobe);
        int nb, cyc, wi, guard;
        bit frame_ok, quiet;
        logic [7:0] scc;
        nb  = (ek == 3'd0) ? 0 : (ek == 3'd2) ? 3 : 12;
        scc = (ek == 3'd2) ? (ccin & 8'h7F) : (ccin | 8'h80);
        @(negedge clk) boundary = 1'b1;
        @(negedge clk) boundary = 1'b0;
        if (ek == 3'd7) begin
            quiet = 1'b1;
            repeat (4) begin
                if (busy) quiet = 1'b0;
                @(negedge clk);
            end
            chk(quiet, "R12 no entry when unrequested or masked", {31'd0, !quiet}, 32'd0);
            return;
        end
        cyc = 0; wi = 0; guard = 0; frame_ok = 1'b1;
        while (!done && guard < 40) begin
            if (busy) cyc++;
            if (mem_we) begin
                if (wi >= nb || mem_addr != 16'h8000 - 16'(wi + 1) || mem_wdata != exp_byte(ek, wi, scc)) begin
                    frame_ok = 1'b0;
                    $display("FAIL R4/R5 write %0d actual=%h:%h expected=%h:%h", wi, mem_addr, mem_wdata,
                             16'h8000 - 16'(wi + 1), exp_byte(ek, wi, scc));
                end
                wi++;
            end
            boundary = (mid_strobe && cyc == 3);
            @(negedge clk);
            guard++;
        end
        boundary = 1'b0;
        if (busy) cyc++;
        chk(done, "R10 done pulse reached", {31'd0, done}, 32'd1);
        chk(frame_ok && wi == nb, "R4/R5 frame bytes", wi, nb);
        chk(cyc == nb + 4, "R10 busy length", cyc, nb + 4);
        chk(kind_out == ek[1:0], "R1/R8 serviced kind", kind_out, ek);
        chk(pc_out == epc, "R7 vector PC", pc_out, epc);
        chk(cc_out == ecc, "R6 updated CC", cc_out, ecc);
        chk(cost == ((ek == 3'd0) ? 8'd0 : (ek == 3'd2) ? 8'd10 : 8'd19), "R8 cost", cost,
            (ek == 3'd0) ? 0 : (ek == 3'd2) ? 10 : 19);
        chk(dp_clear == (ek == 3'd0), "R2 dp clear", dp_clear, ek == 3'd0);
        chk(sp_out == 16'h8000 - 16'(nb), "R4/R5 final S", sp_out, 16'h8000 - 16'(nb));
        @(negedge clk);
        chk(!busy, "R10 idle after done", busy, 0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(!busy, "R11 busy low", busy, 0);
        chk(!done, "R11 done low", done, 0);
        chk(!mem_we && !mem_re, "R11 strobes low", {mem_we, mem_re}, 0);

        // Vector table: R1 R2 R3 R5 R6 R7 R8 R9 R12
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            cc_in     = VECS[v].cc;
            req_reset = VECS[v].req[3];
            req_nmi   = VECS[v].req[2];
            req_firq  = VECS[v].req[1];
            req_irq   = VECS[v].req[0];
            @(negedge clk) req_reset = 1'b0;
            serve(VECS[v].kind, VECS[v].cc, VECS[v].ccout, VECS[v].pc, 1'b0);
            req_nmi = 0; req_firq = 0; req_irq = 0;
            repeat (2) @(negedge clk);
        end

        // R3: edge held pending behind a reset, then served once only
        cc_in = 8'h00;
        req_reset = 1'b1; req_nmi = 1'b1;
        @(negedge clk) req_reset = 1'b0;
        serve(3'd0, 8'h00, 8'h50, 16'hDEF0, 1'b0);
        serve(3'd1, 8'h00, 8'hD0, 16'h9ABC, 1'b0);
        serve(3'd7, 8'h00, 8'h00, 16'h0000, 1'b0);
        req_nmi = 1'b0;
        repeat (2) @(negedge clk);

        // R10 strobe while busy ignored; R9 level request taken again
        cc_in = 8'h00; req_irq = 1'b1;
        serve(3'd3, 8'h00, 8'h90, 16'h5678, 1'b1);
        begin
            bit quiet = 1'b1;
            repeat (4) begin
                if (busy) quiet = 1'b0;
                @(negedge clk);
            end
            chk(quiet, "R10 strobe during busy ignored", {31'd0, !quiet}, 32'd0);
        end
        serve(3'd3, 8'h00, 8'h90, 16'h5678, 1'b0);
        req_irq = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule